// File: doc/BRIEF.md
# Backward Stage Calibration Sequencer

This block orders one complete background calibration pass over the five front stages of a pipelined converter, then keeps repeating passes. Stage 5 is handled first and stage 1 last. The stages that are not being calibrated form the measuring sub-converter. Because the pass runs backward, every later stage in that sub-converter has already been corrected during the same pass. For each stage the sequencer runs eight measurements on an external correlator. The correlator is started with a one-cycle pulse, and the sequencer waits for its done strobe. Each returned value is added into a running sum.

Once the four fragment results of one decision value are in, the sum is written out as that decision's correction coefficient. After both nonzero decisions, a zero coefficient is written for the middle decision. The stage then hands over to the one before it.

On request, the first pass runs in a fast power-up mode. In this mode the correlation length is much shorter and a request to short the converter input to zero is raised. The request is released when that pass ends, and all later passes use the long normal length.

Top module: `bwd_cal_seq`

## Requirements
- R1: After reset the block is idle: `corr_start`, `coef_we` and `input_short` are 0, and they stay 0 until `start` is seen.
- R2: A pass started with `fast_first`=1 holds `input_short`=1 and `corr_log2m`=LOG2M_FAST for every measurement of that pass. Every later pass, and every pass started with `fast_first`=0, holds `input_short`=0 and `corr_log2m`=LOG2M_NORM.
- R3: Measurements visit stages through `sel_stage` in the order 5, 4, 3, 2, 1. After stage 1 the order restarts at 5 with no further `start`.
- R4: Within a stage, `sel_dec`=0 (decision −1) comes first, then `sel_dec`=1 (decision +1). For each decision, `sel_frag` runs 0, 1, 2, 3, which selects fragments 1 to 4.
- R5: `corr_start` is a single-cycle pulse. After it, no further pulse occurs and `sel_stage`/`sel_dec`/`sel_frag` stay stable until `corr_done` has been received.
- R6: The coefficient for a decision is the signed sum of its four correlator values, sign-extended to COEF_W. It is written once, in the cycle after the fourth `corr_done`, with `coef_sel`=00 for −1 and 10 for +1.
- R7: Each stage's last write has `coef_sel`=01 (decision 0) and `coef_data`=0.
- R8: Per stage the writes come in the order −1, +1, 0, all with `coef_stage` equal to the stage just measured. The code 11 never appears.
- R9: `start` (and `fast_first`) have no effect while a pass is running.
- R10: `srst` returns the block to idle in the next cycle: no start pulse, no write, `input_short`=0, and the running sum is cleared.
- R11: `corr_done` received while no measurement is outstanding changes neither the outputs nor any later coefficient.
- R12: During each measurement, `corr_en_mask` bit k (stage k+1) is 1 exactly when stage k+1 is later than `sel_stage`. These are the calibrated stages whose corrections apply inside the measuring sub-converter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst | input | 1 | Synchronous return to idle |
| start | input | 1 | Begin calibration passes (sampled when idle) |
| fast_first | input | 1 | First pass uses the fast power-up mode |
| corr_done | input | 1 | Correlator result strobe |
| corr_val | input | MEAS_W | Signed correlator result |
| corr_start | output | 1 | One-cycle correlator start |
| corr_log2m | output | LOG2M_W | log2 of the correlation length |
| input_short | output | 1 | Request to short the converter input to zero |
| sel_stage | output | STG_W | Stage under calibration (1..NUM_STAGES) |
| sel_dec | output | 1 | Decision value: 0 = −1, 1 = +1 |
| sel_frag | output | FRG_W | Capacitor fragment index minus one |
| corr_en_mask | output | NUM_STAGES | Corrected stages inside the measuring sub-converter |
| coef_we | output | 1 | Coefficient write strobe |
| coef_stage | output | STG_W | Stage of the written coefficient |
| coef_sel | output | 2 | Decision of the written coefficient: 00 −1, 01 zero, 10 +1 |
| coef_data | output | COEF_W | Signed coefficient value |

## Verification
The bench builds the block with five stages, four fragments and an 8-bit correlator word. This keeps the ±full-scale sums (−512 and +508) small enough to drive on purpose for one stage, while the other stages get arithmetic patterns. Every stage, decision and fragment combination is walked through in a fast pass and in a following normal pass, with correlator latencies of one to four cycles. An interrupted fast pass, stray done strobes and a mid-pass start request test that control stays confined to its loop.

// File: rtl/bwd_cal_seq_pkg.sv
package bwd_cal_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_WAIT,
    SQ_WR_DEC,
    SQ_WR_ZERO
  } sq_state_e;

  // coefficient select codes on the write port
  localparam logic [1:0] CSEL_NEG  = 2'b00;
  localparam logic [1:0] CSEL_ZERO = 2'b01;
  localparam logic [1:0] CSEL_POS  = 2'b10;

endpackage

// File: rtl/bwd_cal_seq_idx.sv
// Loop indices: stage (outer, counting down), decision, fragment (inner).
module bwd_cal_seq_idx #(
  parameter int NUM_STAGES = 5,
  parameter int NUM_FRAG   = 4,
  localparam int STG_W = $clog2(NUM_STAGES + 1),
  localparam int FRG_W = $clog2(NUM_FRAG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             idx_init,
  input  logic             frag_adv,
  input  logic             dec_adv,
  input  logic             stage_adv,
  output logic [STG_W-1:0] stage_q,
  output logic             dec_q,
  output logic [FRG_W-1:0] frag_q,
  output logic             last_frag,
  output logic             first_stage
);

  localparam logic [STG_W-1:0] STG_TOP  = STG_W'(NUM_STAGES);
  localparam logic [STG_W-1:0] STG_ONE  = STG_W'(1);
  localparam logic [FRG_W-1:0] FRG_LAST = FRG_W'(NUM_FRAG - 1);

  logic [STG_W-1:0] stage_d;
  logic             dec_d;
  logic [FRG_W-1:0] frag_d;
  logic             idx_en;

  assign last_frag   = (frag_q == FRG_LAST);
  assign first_stage = (stage_q == STG_ONE);
  assign idx_en      = idx_init | frag_adv | dec_adv | stage_adv;

  always_comb begin
    stage_d = stage_q;
    dec_d   = dec_q;
    frag_d  = frag_q;
    if (idx_init) begin
      stage_d = STG_TOP;
      dec_d   = 1'b0;
      frag_d  = '0;
    end else if (stage_adv) begin
      stage_d = first_stage ? STG_TOP : (stage_q - STG_ONE);
      dec_d   = 1'b0;
      frag_d  = '0;
    end else if (dec_adv) begin
      dec_d   = 1'b1;
      frag_d  = '0;
    end else if (frag_adv) begin
      frag_d  = last_frag ? '0 : (frag_q + FRG_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_TOP;
      dec_q   <= 1'b0;
      frag_q  <= '0;
    end else if (srst) begin
      stage_q <= STG_TOP;
      dec_q   <= 1'b0;
      frag_q  <= '0;
    end else if (idx_en) begin
      stage_q <= stage_d;
      dec_q   <= dec_d;
      frag_q  <= frag_d;
    end
  end

endmodule

// File: rtl/bwd_cal_seq_acc.sv
// Running signed sum of correlator results for one decision value.
module bwd_cal_seq_acc #(
  parameter int MEAS_W = 24,
  parameter int COEF_W = 26
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     srst,
  input  logic                     acc_clr,
  input  logic                     acc_add,
  input  logic signed [MEAS_W-1:0] din,
  output logic signed [COEF_W-1:0] sum_q
);

  localparam int EXT_W = COEF_W - MEAS_W;

  logic signed [COEF_W-1:0] din_ext;
  logic signed [COEF_W-1:0] sum_d;
  logic                     acc_en;

  assign din_ext = {{EXT_W{din[MEAS_W-1]}}, din};
  assign acc_en  = acc_clr | acc_add;

  always_comb begin
    if (acc_clr) sum_d = '0;
    else         sum_d = sum_q + din_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (srst)   sum_q <= '0;
    else if (acc_en) sum_q <= sum_d;
  end

endmodule

// File: rtl/bwd_cal_seq_fsm.sv
// Measurement and coefficient-write control.
module bwd_cal_seq_fsm
  import bwd_cal_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic start,
  input  logic fast_first,
  input  logic corr_done,
  input  logic last_frag,
  input  logic cur_dec,
  input  logic first_stage,
  output logic corr_start,
  output logic idx_init,
  output logic frag_adv,
  output logic dec_adv,
  output logic stage_adv,
  output logic acc_add,
  output logic acc_clr,
  output logic coef_we,
  output logic coef_zero,
  output logic fast_q
);

  sq_state_e state_q, state_d;
  logic      fast_d;
  logic      fast_en;

  always_comb begin
    state_d    = state_q;
    fast_d     = fast_q;
    fast_en    = 1'b0;
    corr_start = 1'b0;
    idx_init   = 1'b0;
    frag_adv   = 1'b0;
    dec_adv    = 1'b0;
    stage_adv  = 1'b0;
    acc_add    = 1'b0;
    acc_clr    = 1'b0;
    coef_we    = 1'b0;
    coef_zero  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          idx_init = 1'b1;
          fast_d   = fast_first;
          fast_en  = 1'b1;
          state_d  = SQ_ISSUE;
        end
      end
      SQ_ISSUE: begin
        corr_start = 1'b1;
        state_d    = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (corr_done) begin
          acc_add  = 1'b1;
          frag_adv = 1'b1;
          state_d  = last_frag ? SQ_WR_DEC : SQ_ISSUE;
        end
      end
      SQ_WR_DEC: begin
        coef_we = 1'b1;
        acc_clr = 1'b1;
        if (!cur_dec) begin
          dec_adv = 1'b1;
          state_d = SQ_ISSUE;
        end else begin
          state_d = SQ_WR_ZERO;
        end
      end
      SQ_WR_ZERO: begin
        coef_we   = 1'b1;
        coef_zero = 1'b1;
        stage_adv = 1'b1;
        if (first_stage) begin
          fast_d  = 1'b0;
          fast_en = 1'b1;
        end
        state_d = SQ_ISSUE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      fast_q  <= 1'b0;
    end else if (srst) begin
      state_q <= SQ_IDLE;
      fast_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fast_en) fast_q <= fast_d;
    end
  end

endmodule

// File: rtl/bwd_cal_seq.sv
module bwd_cal_seq
  import bwd_cal_seq_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int NUM_FRAG   = 4,
  parameter int MEAS_W     = 24,
  parameter int LOG2M_W    = 5,
  parameter int LOG2M_FAST = 16,
  parameter int LOG2M_NORM = 28,
  localparam int STG_W  = $clog2(NUM_STAGES + 1),
  localparam int FRG_W  = $clog2(NUM_FRAG),
  localparam int COEF_W = MEAS_W + $clog2(NUM_FRAG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     srst,
  input  logic                     start,
  input  logic                     fast_first,
  input  logic                     corr_done,
  input  logic signed [MEAS_W-1:0] corr_val,
  output logic                     corr_start,
  output logic [LOG2M_W-1:0]       corr_log2m,
  output logic                     input_short,
  output logic [STG_W-1:0]         sel_stage,
  output logic                     sel_dec,
  output logic [FRG_W-1:0]         sel_frag,
  output logic [NUM_STAGES-1:0]    corr_en_mask,
  output logic                     coef_we,
  output logic [STG_W-1:0]         coef_stage,
  output logic [1:0]               coef_sel,
  output logic signed [COEF_W-1:0] coef_data
);

  logic idx_init, frag_adv, dec_adv, stage_adv;
  logic acc_add, acc_clr, coef_zero;
  logic last_frag, first_stage;
  logic signed [COEF_W-1:0] sum_q;

  bwd_cal_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .srst        (srst),
    .start       (start),
    .fast_first  (fast_first),
    .corr_done   (corr_done),
    .last_frag   (last_frag),
    .cur_dec     (sel_dec),
    .first_stage (first_stage),
    .corr_start  (corr_start),
    .idx_init    (idx_init),
    .frag_adv    (frag_adv),
    .dec_adv     (dec_adv),
    .stage_adv   (stage_adv),
    .acc_add     (acc_add),
    .acc_clr     (acc_clr),
    .coef_we     (coef_we),
    .coef_zero   (coef_zero),
    .fast_q      (input_short)
  );

  bwd_cal_seq_idx #(
    .NUM_STAGES (NUM_STAGES),
    .NUM_FRAG   (NUM_FRAG)
  ) u_idx (
    .clk         (clk),
    .rst_n       (rst_n),
    .srst        (srst),
    .idx_init    (idx_init),
    .frag_adv    (frag_adv),
    .dec_adv     (dec_adv),
    .stage_adv   (stage_adv),
    .stage_q     (sel_stage),
    .dec_q       (sel_dec),
    .frag_q      (sel_frag),
    .last_frag   (last_frag),
    .first_stage (first_stage)
  );

  bwd_cal_seq_acc #(
    .MEAS_W (MEAS_W),
    .COEF_W (COEF_W)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst),
    .acc_clr (acc_clr),
    .acc_add (acc_add),
    .din     (corr_val),
    .sum_q   (sum_q)
  );

  // stages later than the one being measured are already corrected
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_mask
    localparam logic [STG_W-1:0] STG_ID = STG_W'(k + 1);
    assign corr_en_mask[k] = (STG_ID > sel_stage);
  end

  assign corr_log2m = input_short ? LOG2M_W'(LOG2M_FAST) : LOG2M_W'(LOG2M_NORM);
  assign coef_stage = sel_stage;
  assign coef_sel   = coef_zero ? CSEL_ZERO : (sel_dec ? CSEL_POS : CSEL_NEG);
  assign coef_data  = coef_zero ? '0 : sum_q;

endmodule

// File: rtl/bwd_cal_seq_chk.sv
module bwd_cal_seq_chk #(
  parameter int NUM_STAGES = 5,
  parameter int STG_W      = 3,
  parameter int FRG_W      = 2,
  parameter int COEF_W     = 26,
  parameter int LOG2M_W    = 5,
  parameter int LOG2M_FAST = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  srst,
  input logic                  corr_start,
  input logic [STG_W-1:0]      sel_stage,
  input logic                  sel_dec,
  input logic [FRG_W-1:0]      sel_frag,
  input logic [NUM_STAGES-1:0] corr_en_mask,
  input logic                  input_short,
  input logic [LOG2M_W-1:0]    corr_log2m,
  input logic                  coef_we,
  input logic [1:0]            coef_sel,
  input logic [COEF_W-1:0]     coef_data
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    corr_start |=> !corr_start); // R5

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_start && !srst) |=> $stable({sel_stage, sel_dec, sel_frag})); // R5

  AST_STAGE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    corr_start |-> (sel_stage >= STG_W'(1) && sel_stage <= STG_W'(NUM_STAGES))); // R3

  AST_SHORT_FAST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    input_short |-> (corr_log2m == LOG2M_W'(LOG2M_FAST))); // R2

  AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_we && coef_sel == 2'b01) |-> (coef_data == '0)); // R7

  AST_SEL_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |-> (coef_sel != 2'b11)); // R8

  AST_MASK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    corr_start |-> ($countones(corr_en_mask) == NUM_STAGES - int'(sel_stage))); // R12

  AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!corr_start && !coef_we && !input_short)); // R10

endmodule

bind bwd_cal_seq bwd_cal_seq_chk #(
  .NUM_STAGES (NUM_STAGES),
  .STG_W      (STG_W),
  .FRG_W      (FRG_W),
  .COEF_W     (COEF_W),
  .LOG2M_W    (LOG2M_W),
  .LOG2M_FAST (LOG2M_FAST)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .srst         (srst),
  .corr_start   (corr_start),
  .sel_stage    (sel_stage),
  .sel_dec      (sel_dec),
  .sel_frag     (sel_frag),
  .corr_en_mask (corr_en_mask),
  .input_short  (input_short),
  .corr_log2m   (corr_log2m),
  .coef_we      (coef_we),
  .coef_sel     (coef_sel),
  .coef_data    (coef_data)
);

// File: tb/bwd_cal_seq_test.sv
`timescale 1ns/1ps
module bwd_cal_seq_test;

  localparam int NS = 5;
  localparam int MW = 8;
  localparam int CW = 10;

  logic clk, rst_n, srst, start, fast_first, corr_done;
  logic signed [MW-1:0] corr_val;
  logic corr_start, input_short, sel_dec, coef_we;
  logic [4:0] corr_log2m;
  logic [2:0] sel_stage, coef_stage;
  logic [1:0] sel_frag, coef_sel;
  logic [NS-1:0] corr_en_mask;
  logic signed [CW-1:0] coef_data;

  bwd_cal_seq #(.NUM_STAGES(NS), .NUM_FRAG(4), .MEAS_W(MW)) uut (
    .clk(clk), .rst_n(rst_n), .srst(srst), .start(start), .fast_first(fast_first),
    .corr_done(corr_done), .corr_val(corr_val), .corr_start(corr_start),
    .corr_log2m(corr_log2m), .input_short(input_short), .sel_stage(sel_stage),
    .sel_dec(sel_dec), .sel_frag(sel_frag), .corr_en_mask(corr_en_mask),
    .coef_we(coef_we), .coef_stage(coef_stage), .coef_sel(coef_sel),
    .coef_data(coef_data));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks, errors;
  bit finished;
  int exp_stage, exp_dec, exp_frag, cyc_idx, meas_n, wr_k, wr_stage;
  bit fast_exp, r9_pending;
  int sum_neg[1:NS];
  int sum_pos[1:NS];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int meas_val(input int n, input int stg, input int dec);
    if (stg == 2) return (dec != 0) ? 127 : -128;
    return ((n * 37 + 11) % 256) - 128;
  endfunction

  task automatic restart_expect(input bit fast);
    exp_stage = NS; exp_dec = 0; exp_frag = 0; cyc_idx = 0;
    fast_exp = fast; wr_k = 0; wr_stage = NS;
    for (int s = 1; s <= NS; s++) begin sum_neg[s] = 0; sum_pos[s] = 0; end
  endtask

  task automatic idle_check(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(corr_start == 1'b0, req, int'(corr_start), 0);
      chk(coef_we == 1'b0, req, int'(coef_we), 0);
      chk(input_short == 1'b0, req, int'(input_short), 0);
    end
  endtask

  task automatic stray_done(input int v);
    @(posedge clk); #1;
    corr_done = 1'b1; corr_val = MW'(v);
    @(posedge clk); #1;
    corr_done = 1'b0;
  endtask

  // correlator model and per-measurement checks
  initial begin : responder
    int v, lat, expmask;
    logic [2:0] s0; logic d0; logic [1:0] f0;
    forever begin
      @(negedge clk);
      if (corr_start === 1'b1) begin
        chk(int'(sel_stage) == exp_stage, "R3 stage order", int'(sel_stage), exp_stage);
        chk(int'(sel_dec) == exp_dec, "R4 decision order", int'(sel_dec), exp_dec);
        chk(int'(sel_frag) == exp_frag, "R4 fragment order", int'(sel_frag), exp_frag);
        chk(input_short == fast_exp, "R2 short request", int'(input_short), int'(fast_exp));
        chk(int'(corr_log2m) == (fast_exp ? 16 : 28), "R2 length", int'(corr_log2m),
            fast_exp ? 16 : 28);
        expmask = ((1 << NS) - 1) & ~((1 << exp_stage) - 1);
        chk(int'(corr_en_mask) == expmask, "R12 corrected mask", int'(corr_en_mask), expmask);
        if (r9_pending) begin
          chk(int'(sel_stage) == exp_stage && input_short == fast_exp, "R9 start ignored",
              int'(sel_stage), exp_stage);
          r9_pending = 1'b0;
        end
        s0 = sel_stage; d0 = sel_dec; f0 = sel_frag;
        v = meas_val(meas_n, exp_stage, exp_dec);
        lat = 1 + (meas_n % 4);
        meas_n++;
        if (exp_dec == 0) begin
          if (exp_frag == 0) sum_neg[exp_stage] = 0;
          sum_neg[exp_stage] += v;
        end else begin
          if (exp_frag == 0) sum_pos[exp_stage] = 0;
          sum_pos[exp_stage] += v;
        end
        exp_frag++;
        if (exp_frag == 4) begin
          exp_frag = 0;
          if (exp_dec == 0) exp_dec = 1;
          else begin
            exp_dec = 0;
            if (exp_stage == 1) begin exp_stage = NS; cyc_idx++; fast_exp = 1'b0; end
            else exp_stage--;
          end
        end
        for (int k = 1; k <= lat; k++) begin
          @(posedge clk); #1;
          if (k == lat) begin corr_done = 1'b1; corr_val = MW'(v); end
          @(negedge clk);
          chk(corr_start == 1'b0, "R5 single pulse", int'(corr_start), 0);
          chk(sel_stage == s0 && sel_dec == d0 && sel_frag == f0, "R5 selects held",
              int'({sel_stage, sel_dec, sel_frag}), int'({s0, d0, f0}));
        end
        @(posedge clk); #1;
        corr_done = 1'b0;
      end
    end
  end

  // coefficient write checks
  always @(negedge clk) begin
    if (coef_we === 1'b1) begin
      chk(int'(coef_stage) == wr_stage, "R8 write stage", int'(coef_stage), wr_stage);
      if (wr_k == 0) begin
        chk(coef_sel == 2'b00, "R8 first write is -1", int'(coef_sel), 0);
        chk(int'(coef_data) == sum_neg[wr_stage], "R6 sum for -1", int'(coef_data),
            sum_neg[wr_stage]);
      end else if (wr_k == 1) begin
        chk(coef_sel == 2'b10, "R8 second write is +1", int'(coef_sel), 2);
        chk(int'(coef_data) == sum_pos[wr_stage], "R6 sum for +1", int'(coef_data),
            sum_pos[wr_stage]);
      end else begin
        chk(coef_sel == 2'b01, "R7 zero select", int'(coef_sel), 1);
        chk(int'(coef_data) == 0, "R7 zero value", int'(coef_data), 0);
      end
      wr_k++;
      if (wr_k == 3) begin
        wr_k = 0;
        wr_stage = (wr_stage == 1) ? NS : wr_stage - 1;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    checks = 0; errors = 0; finished = 1'b0; meas_n = 0; r9_pending = 1'b0;
    rst_n = 1'b0; srst = 1'b0; start = 1'b0; fast_first = 1'b0;
    corr_done = 1'b0; corr_val = '0;
    restart_expect(1'b1);
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    idle_check(8, "R1 reset idle");

    // stray done while idle, then fast pass interrupted by srst
    stray_done(77);
    idle_check(4, "R11 stray done idle");
    restart_expect(1'b1);
    @(posedge clk); #1; start = 1'b1; fast_first = 1'b1;
    @(posedge clk); #1; start = 1'b0; fast_first = 1'b0;
    while (!(cyc_idx == 0 && exp_stage == 3 && exp_frag == 2)) @(negedge clk);
    @(posedge clk); #1; srst = 1'b1;
    @(posedge clk); #1; srst = 1'b0;
    idle_check(12, "R10 srst idle");

    // stray done after srst must not enter the next sums
    stray_done(-55);
    idle_check(3, "R11 stray done after srst");
    restart_expect(1'b1);
    @(posedge clk); #1; start = 1'b1; fast_first = 1'b1;
    @(posedge clk); #1; start = 1'b0; fast_first = 1'b0;
    while (!(cyc_idx == 1 && exp_stage == 4 && exp_frag == 1)) @(negedge clk);
    @(posedge clk); #1; start = 1'b1; fast_first = 1'b1; r9_pending = 1'b1;
    @(posedge clk); #1; start = 1'b0; fast_first = 1'b0;
    while (cyc_idx < 2) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(wr_k == 0 && wr_stage == NS, "R8 all writes of pass", wr_stage, NS);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule